// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block sits between a management agent that wants to read or write a PHY register and a switch register port that only understands 16-bit register transactions. One PHY access becomes a short chain of switch-register transactions. The first is a write to an access-control register that sets the direction. The second is a write to a synthetic address: a one-hot PHY select and the register number are packed into a fixed high address window. A read then adds a third transaction, a read of an access-data register, and that value is returned as the PHY register content.

The upstream side takes one request at a time with a valid/ready handshake and reports completion with a one-cycle done pulse, an error flag and the read data. The downstream side is a plain request/acknowledge register port. The block holds a request until the port acknowledges it, and the acknowledge carries the response data and an error indication. A PHY number above the supported range is refused at once, and no downstream traffic is issued for it. An error reported by the port ends the sequence at the failing step.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset, req_ready_o is 1, done_o, err_o and dn_req_o are 0, and rdata_o is 0.
- R2: For an accepted request with a valid PHY number (0 to 4), the first downstream transaction is a write (dn_write_o=1) to address 0x8028 with data 1 for a read request and 0 for a write request (req_write_i=1 means write).
- R3: The second downstream transaction is a write to address 0x8000 | (1 << (phy + 9)) | reg[4:0]. Its data is req_wdata_i for a write request and 0 for a read request.
- R4: A read request issues a third transaction, a read (dn_write_o=0) of address 0x8029. The dn_rdata_i value acknowledged with it appears on rdata_o in the done cycle.
- R5: A write request issues exactly two transactions, ends with err_o=0, and leaves rdata_o at 0.
- R6: A PHY number greater than 4 issues no downstream transaction. done_o and err_o are both 1 in the cycle after acceptance.
- R7: Bits of req_reg_i above bit 4 have no effect on any downstream address or data.
- R8: If an acknowledge arrives with dn_err_i=1, no further transaction is issued. done_o and err_o are 1 in the following cycle, and rdata_o is 0.
- R9: req_ready_o is 0 from the cycle after acceptance through the done cycle. done_o lasts one cycle and is followed by req_ready_o=1.
- R10: While dn_req_o is 1 and not yet acknowledged, dn_addr_o, dn_wdata_o and dn_write_o stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | PHY access request valid |
| req_ready_o | output | 1 | Bridge idle, request accepted when valid |
| req_write_i | input | 1 | 1 for a PHY write, 0 for a PHY read |
| req_phy_i | input | PHY_W (3) | PHY number |
| req_reg_i | input | REG_IN_W (8) | Register number, low 5 bits used |
| req_wdata_i | input | DATA_W (16) | PHY write data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Access failed, valid with done_o |
| rdata_o | output | DATA_W (16) | PHY read data, valid with done_o |
| dn_req_o | output | 1 | Downstream transaction request |
| dn_write_o | output | 1 | Downstream transaction is a write |
| dn_addr_o | output | ADDR_W (16) | Downstream switch register address |
| dn_wdata_o | output | DATA_W (16) | Downstream write data |
| dn_ack_i | input | 1 | Downstream transaction complete |
| dn_err_i | input | 1 | Downstream transaction failed, valid with dn_ack_i |
| dn_rdata_i | input | DATA_W (16) | Downstream read data, valid with dn_ack_i |

## Verification
The properties assume that the register port raises dn_ack_i only while dn_req_o is high, and that it never acknowledges in the cycle right after a previous acknowledge. They also assume that upstream requests are presented only through the ready handshake. The bench's port model follows these rules. It acknowledges after a latency of zero to two idle cycles, returns read data derived from the last synthetic address, and can fail a chosen transaction index. The sweep covers every PHY number the 3-bit field can carry, all 32 register numbers with varying upper junk bits, and both directions. Error injection runs at every step of both sequence kinds.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_SEL,
    ST_FETCH,
    ST_FIN
  } bridge_st_e;
endpackage

// File: rtl/phy_bridge_addr.sv
module phy_bridge_addr #(
  parameter int unsigned PHY_W     = 3,
  parameter int unsigned PHY_MAX   = 4,
  parameter int unsigned REG_IN_W  = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SEL_SHIFT = 9,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000
) (
  input  logic [PHY_W-1:0]    phy_i,
  input  logic [REG_IN_W-1:0] reg_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                phy_ok_o
);
  localparam int unsigned REG_FIELD_W = 5;
  localparam logic [PHY_W:0] PHY_LIMIT = (PHY_W+1)'(PHY_MAX);

  logic [ADDR_W-1:0] sel_onehot;
  logic [ADDR_W-1:0] reg_field;
  logic              unused_reg_hi;

  for (genvar g = 0; g < ADDR_W; g++) begin : g_sel
    if (g >= SEL_SHIFT && g <= SEL_SHIFT + PHY_MAX) begin : g_on
      localparam logic [PHY_W-1:0] PHY_ID = PHY_W'(g - SEL_SHIFT);
      assign sel_onehot[g] = (phy_i == PHY_ID);
    end else begin : g_off
      assign sel_onehot[g] = 1'b0;
    end
  end

  assign reg_field     = ADDR_W'(reg_i[REG_FIELD_W-1:0]);
  assign unused_reg_hi = ^reg_i[REG_IN_W-1:REG_FIELD_W];
  assign addr_o        = WIN_BASE | sel_onehot | reg_field;
  assign phy_ok_o      = ({1'b0, phy_i} <= PHY_LIMIT);
endmodule

// File: rtl/phy_bridge_seq.sv
module phy_bridge_seq
  import phy_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h8028,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h8029
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              phy_ok_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] sel_addr_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dn_req_o,
  output logic              dn_write_o,
  output logic [ADDR_W-1:0] dn_addr_o,
  output logic [DATA_W-1:0] dn_wdata_o,
  input  logic              dn_ack_i,
  input  logic              dn_err_i,
  input  logic [DATA_W-1:0] dn_rdata_i
);
  bridge_st_e        st_q;
  logic              err_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          rdata_q <= '0;
          err_q   <= !phy_ok_i;
          st_q    <= phy_ok_i ? ST_CTRL : ST_FIN;
        end
        ST_CTRL: if (dn_ack_i) begin
          err_q <= dn_err_i;
          st_q  <= dn_err_i ? ST_FIN : ST_SEL;
        end
        ST_SEL: if (dn_ack_i) begin
          err_q <= dn_err_i;
          st_q  <= (dn_err_i || write_i) ? ST_FIN : ST_FETCH;
        end
        ST_FETCH: if (dn_ack_i) begin
          err_q <= dn_err_i;
          if (!dn_err_i) rdata_q <= dn_rdata_i;
          st_q  <= ST_FIN;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dn_req_o   = 1'b0;
    dn_write_o = 1'b0;
    dn_addr_o  = '0;
    dn_wdata_o = '0;
    unique case (st_q)
      ST_CTRL: begin
        dn_req_o   = 1'b1;
        dn_write_o = 1'b1;
        dn_addr_o  = CTRL_ADDR;
        dn_wdata_o = DATA_W'(!write_i);
      end
      ST_SEL: begin
        dn_req_o   = 1'b1;
        dn_write_o = 1'b1;
        dn_addr_o  = sel_addr_i;
        dn_wdata_o = write_i ? wdata_i : '0;
      end
      ST_FETCH: begin
        dn_req_o   = 1'b1;
        dn_addr_o  = DATA_ADDR;
      end
      default: ;
    endcase
  end

  assign ready_o = (st_q == ST_IDLE);
  assign done_o  = (st_q == ST_FIN);
  assign err_o   = done_o & err_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge #(
  parameter int unsigned PHY_W     = 3,
  parameter int unsigned PHY_MAX   = 4,
  parameter int unsigned REG_IN_W  = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned SEL_SHIFT = 9,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h8000,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h8028,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h8029
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_write_i,
  input  logic [PHY_W-1:0]    req_phy_i,
  input  logic [REG_IN_W-1:0] req_reg_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                done_o,
  output logic                err_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                dn_req_o,
  output logic                dn_write_o,
  output logic [ADDR_W-1:0]   dn_addr_o,
  output logic [DATA_W-1:0]   dn_wdata_o,
  input  logic                dn_ack_i,
  input  logic                dn_err_i,
  input  logic [DATA_W-1:0]   dn_rdata_i
);
  logic              accept;
  logic              phy_ok;
  logic [ADDR_W-1:0] sel_addr;
  logic [ADDR_W-1:0] sel_addr_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;

  assign accept = req_valid_i & req_ready_o;

  phy_bridge_addr #(
    .PHY_W(PHY_W), .PHY_MAX(PHY_MAX), .REG_IN_W(REG_IN_W),
    .ADDR_W(ADDR_W), .SEL_SHIFT(SEL_SHIFT), .WIN_BASE(WIN_BASE)
  ) u_addr (
    .phy_i(req_phy_i),
    .reg_i(req_reg_i),
    .addr_o(sel_addr),
    .phy_ok_o(phy_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_addr_q <= '0;
      write_q    <= 1'b0;
      wdata_q    <= '0;
    end else if (accept) begin
      sel_addr_q <= sel_addr;
      write_q    <= req_write_i;
      wdata_q    <= req_wdata_i;
    end
  end

  phy_bridge_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_seq (
    .clk_i(clk_i),
    .rst_ni(rst_ni),
    .start_i(accept),
    .phy_ok_i(phy_ok),
    .write_i(write_q),
    .wdata_i(wdata_q),
    .sel_addr_i(sel_addr_q),
    .ready_o(req_ready_o),
    .done_o(done_o),
    .err_o(err_o),
    .rdata_o(rdata_o),
    .dn_req_o(dn_req_o),
    .dn_write_o(dn_write_o),
    .dn_addr_o(dn_addr_o),
    .dn_wdata_o(dn_wdata_o),
    .dn_ack_i(dn_ack_i),
    .dn_err_i(dn_err_i),
    .dn_rdata_i(dn_rdata_i)
  );
endmodule

// File: rtl/phy_bridge_chk.sv
module phy_bridge_chk #(
  parameter int unsigned PHY_W    = 3,
  parameter int unsigned PHY_MAX  = 4,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h8028,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h8029
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_write_i,
  input logic [PHY_W-1:0]  req_phy_i,
  input logic              done_o,
  input logic              err_o,
  input logic              dn_req_o,
  input logic              dn_write_o,
  input logic [ADDR_W-1:0] dn_addr_o,
  input logic [DATA_W-1:0] dn_wdata_o,
  input logic              dn_ack_i,
  input logic              dn_err_i
);
  logic bad_phy;
  assign bad_phy = (int'(req_phy_i) > int'(PHY_MAX));

  p_first_ctrl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !bad_phy |=>
      dn_req_o && dn_write_o && dn_addr_o == CTRL_ADDR &&
      dn_wdata_o == DATA_W'(!$past(req_write_i)));

  p_fetch_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && !dn_write_o |-> dn_addr_o == DATA_ADDR);

  p_bad_phy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && bad_phy |=> done_o && err_o && !dn_req_o);

  p_err_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && dn_ack_i && dn_err_i |=> done_o && err_o && !dn_req_o);

  p_busy_not_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |-> !req_ready_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o && !dn_ack_i |=>
      dn_req_o && $stable(dn_addr_o) && $stable(dn_wdata_o) && $stable(dn_write_o));
endmodule

bind phy_reg_bridge phy_bridge_chk #(
  .PHY_W(PHY_W), .PHY_MAX(PHY_MAX), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_write_i(req_write_i), .req_phy_i(req_phy_i),
  .done_o(done_o), .err_o(err_o),
  .dn_req_o(dn_req_o), .dn_write_o(dn_write_o),
  .dn_addr_o(dn_addr_o), .dn_wdata_o(dn_wdata_o),
  .dn_ack_i(dn_ack_i), .dn_err_i(dn_err_i)
);

// File: tb/phy_reg_bridge_tb_top.sv
module phy_reg_bridge_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [2:0]  req_phy_i = '0;
  logic [7:0]  req_reg_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        done_o, err_o;
  logic [15:0] rdata_o;
  logic        dn_req_o, dn_write_o;
  logic [15:0] dn_addr_o, dn_wdata_o;
  logic        dn_ack_i = 1'b0;
  logic        dn_err_i = 1'b0;
  logic [15:0] dn_rdata_i = '0;

  int n_chk = 0;
  int n_fail = 0;

  // port model state
  int          n_txn;
  int          err_at;
  int          lat;
  int          wcnt;
  logic        hold_bad;
  logic [15:0] syn_last;
  logic [15:0] first_addr, first_data;
  logic        first_wr;
  logic [15:0] log_addr [4];
  logic [15:0] log_data [4];
  logic        log_wr   [4];

  always #5 clk_i = ~clk_i;

  phy_reg_bridge dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_write_i(req_write_i), .req_phy_i(req_phy_i),
    .req_reg_i(req_reg_i), .req_wdata_i(req_wdata_i),
    .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
    .dn_req_o(dn_req_o), .dn_write_o(dn_write_o),
    .dn_addr_o(dn_addr_o), .dn_wdata_o(dn_wdata_o),
    .dn_ack_i(dn_ack_i), .dn_err_i(dn_err_i), .dn_rdata_i(dn_rdata_i)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // downstream register port model
  initial begin
    n_txn = 0; err_at = 99; lat = 0; wcnt = 0; hold_bad = 1'b0; syn_last = '0;
    first_addr = '0; first_data = '0; first_wr = 1'b0;
    forever begin
      @(negedge clk_i);
      if (dn_ack_i) begin
        dn_ack_i = 1'b0;
        dn_err_i = 1'b0;
      end else if (dn_req_o) begin
        if (wcnt == 0) begin
          first_addr = dn_addr_o; first_data = dn_wdata_o; first_wr = dn_write_o;
        end else if (first_addr !== dn_addr_o || first_data !== dn_wdata_o ||
                     first_wr !== dn_write_o) begin
          hold_bad = 1'b1;
        end
        if (wcnt >= lat) begin
          if (n_txn < 4) begin
            log_addr[n_txn] = dn_addr_o;
            log_data[n_txn] = dn_wdata_o;
            log_wr[n_txn]   = dn_write_o;
          end
          if (dn_write_o && dn_addr_o != 16'h8028) syn_last = dn_addr_o;
          dn_rdata_i = dn_write_o ? 16'hDEAD : (syn_last ^ 16'h5A5A);
          dn_err_i   = (n_txn == err_at);
          dn_ack_i   = 1'b1;
          n_txn++;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic run_op(int phy, int rg, bit wr, logic [15:0] wd, int ea, int la);
    int          exp_n;
    bit          exp_err;
    logic [15:0] syn, exp_rd;
    n_txn = 0; err_at = ea; lat = la; wcnt = 0; hold_bad = 1'b0;
    @(negedge clk_i);
    chk("R9 ready before request", {31'b0, req_ready_o}, 32'd1);
    req_valid_i = 1'b1; req_write_i = wr; req_phy_i = 3'(phy);
    req_reg_i = 8'(rg); req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int c = 0; c < 40 && !done_o; c++) begin
      chk("R9 ready low while busy", {31'b0, req_ready_o}, 32'd0);
      @(negedge clk_i);
    end
    chk("R9 done seen", {31'b0, done_o}, 32'd1);
    chk("R9 ready low at done", {31'b0, req_ready_o}, 32'd0);
    syn = 16'h8000 | (16'd1 << (phy + 9)) | 16'(rg & 31);
    if (phy > 4) begin
      exp_n = 0; exp_err = 1'b1;
    end else begin
      exp_n = wr ? 2 : 3; exp_err = 1'b0;
      if (ea < exp_n) begin exp_n = ea + 1; exp_err = 1'b1; end
    end
    exp_rd = (!wr && !exp_err) ? (syn ^ 16'h5A5A) : 16'h0;
    if (phy > 4) chk("R6 no transactions for bad phy", n_txn, 0);
    else if (exp_err) chk("R8 stops after failed step", n_txn, exp_n);
    else if (wr) chk("R5 write uses two transactions", n_txn, exp_n);
    else chk("R4 read uses three transactions", n_txn, exp_n);
    chk(phy > 4 ? "R6 err flag" : "R8 err flag", {31'b0, err_o}, {31'b0, exp_err});
    if (exp_n >= 1 && n_txn >= 1) begin
      chk("R2 ctrl addr", log_addr[0], 16'h8028);
      chk("R2 ctrl is write", {31'b0, log_wr[0]}, 32'd1);
      chk("R2 ctrl data", log_data[0], wr ? 16'd0 : 16'd1);
    end
    if (exp_n >= 2 && n_txn >= 2) begin
      chk("R3 R7 select addr", log_addr[1], syn);
      chk("R3 select is write", {31'b0, log_wr[1]}, 32'd1);
      chk("R3 select data", log_data[1], wr ? wd : 16'd0);
    end
    if (exp_n >= 3 && n_txn >= 3) begin
      chk("R4 data reg addr", log_addr[2], 16'h8029);
      chk("R4 data reg is read", {31'b0, log_wr[2]}, 32'd0);
    end
    if (wr) chk("R5 rdata zero", rdata_o, exp_rd);
    else if (exp_err) chk("R8 rdata zero", rdata_o, exp_rd);
    else chk("R4 rdata", rdata_o, exp_rd);
    chk("R10 request held until ack", {31'b0, hold_bad}, 32'd0);
    @(negedge clk_i);
    chk("R9 done single cycle", {31'b0, done_o}, 32'd0);
    chk("R9 ready after done", {31'b0, req_ready_o}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset ready", {31'b0, req_ready_o}, 32'd1);
    chk("R1 reset done", {31'b0, done_o}, 32'd0);
    chk("R1 reset err", {31'b0, err_o}, 32'd0);
    chk("R1 reset dn_req", {31'b0, dn_req_o}, 32'd0);
    chk("R1 reset rdata", rdata_o, 32'd0);
    // sweep: all phy codes, all registers with junk upper bits (R7), both directions
    for (int p = 0; p < 8; p++) begin
      for (int r = 0; r < 32; r++) begin
        for (int w = 0; w < 2; w++) begin
          run_op(p, r | (((r * 5 + p) & 7) << 5), w[0],
                 16'((p * 4099 + r * 257 + w * 31) & 16'hFFFF), 99, (p + r + w) % 3);
        end
      end
    end
    // error injection at each step (R8)
    for (int p = 0; p < 5; p++) begin
      for (int e = 0; e < 3; e++) begin
        run_op(p, 7 + p, 1'b0, 16'h0, e, e % 3);
        if (e < 2) run_op(p, 20 + p, 1'b1, 16'hC3A5, e, (e + 1) % 3);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule